// File: doc/BRIEF.md
# Row Command Spacing Checker

This block sits beside a memory controller's row-command channel and polices the minimum spacing between row commands. Each command is either a precharge or an activate. Each one names a target device and a bank. Every issued command is kept in a short history, together with its age in clock ticks. Each new command is compared against every command still in that history. The spacing a pair needs depends on three things: whether both commands go to the same device, whether they target the same bank or a neighbouring bank, and whether both commands are of the same type.

Two answers come out of the block. A registered violation pulse reports an issued command that arrived too early. A combinational ready flag tells the scheduler whether a candidate command, presented on a separate set of inputs, could go out in the current cycle. The gap values are parameters counted in clock ticks. Bank state tracking is handled elsewhere and is not part of this block.

Top module: `rsc_spacing_checker`

## Requirements
- R1: After reset the history is empty: ready_o is 1 for any candidate, violation_o is 0, and the first command issued raises no violation.
- R2: Two commands to different devices need a gap of T_PACKET (default 4) ticks, whatever their banks and types. Command code 0 is precharge and 1 is activate.
- R3: A precharge and an activate, in either order, to the same device but to banks that are neither equal nor adjacent need a gap of T_PACKET ticks.
- R4: Two commands of the same type to the same device and to non-adjacent banks need a gap of T_PP (default 8) ticks.
- R5: Two commands to the same device and the same bank need a gap of T_BANK (default 12) ticks. When T_PP is larger and the types match, the gap is T_PP.
- R6: Two commands to the same device and to adjacent banks need the same gap as in R5. Banks are adjacent when their numbers differ by one.
- R7: Adjacency never crosses the boundary between the lower and upper halves of the bank range (banks 15 and 16 when there are 32 banks), and it does not wrap around (banks 0 and 31).
- R8: violation_o is 1 for exactly one cycle, the cycle after an issue_i that came sooner than the gap required by some recorded command. Otherwise violation_o is 0.
- R9: ready_o is 1 in the same cycle exactly when the candidate inputs would satisfy every recorded command if issued now.
- R10: The last HIST_DEPTH issued commands are all checked. A command that violated its spacing is still recorded and constrains the commands that follow it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| issue_i | input | 1 | A row command goes out this cycle |
| issue_cmd_i | input | 1 | Issued command type: 0 precharge, 1 activate |
| issue_dev_i | input | DEV_W | Issued command device ID |
| issue_bank_i | input | BANK_W | Issued command bank |
| cand_cmd_i | input | 1 | Candidate command type |
| cand_dev_i | input | DEV_W | Candidate device ID |
| cand_bank_i | input | BANK_W | Candidate bank |
| ready_o | output | 1 | Candidate could be issued now without a violation |
| violation_o | output | 1 | Pulse: the previous cycle's issued command broke a spacing rule |

## Verification
The hardest case to reach is a constraint set by an older command that stays in force while a newer command, which would allow an earlier issue on its own, sits in front of it in the history. The bench sets this up in two steps. First it issues a same-bank command. Then it issues a legal command to another device. It then sweeps the candidate tick by tick across the older entry's window. A second sequence first commits a violating command, then shows that the window is measured from that violating command and not from the legal one before it.

// File: rtl/rsc_pkg.sv
package rsc_pkg;
  typedef enum logic {
    CMD_PRER = 1'b0,
    CMD_ACT  = 1'b1
  } row_cmd_e;

  function automatic int max_int(input int a, input int b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/rsc_history.sv
module rsc_history #(
  parameter int DEPTH  = 4,
  parameter int DEV_W  = 5,
  parameter int BANK_W = 5,
  parameter int AGE_W  = 4,
  parameter int AGE_MAX = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              push_i,
  input  logic              push_cmd_i,
  input  logic [DEV_W-1:0]  push_dev_i,
  input  logic [BANK_W-1:0] push_bank_i,
  output logic              valid_o [DEPTH],
  output logic              cmd_o   [DEPTH],
  output logic [DEV_W-1:0]  dev_o   [DEPTH],
  output logic [BANK_W-1:0] bank_o  [DEPTH],
  output logic [AGE_W-1:0]  age_o   [DEPTH]
);
  localparam logic [AGE_W-1:0] AgeSat = AGE_W'(AGE_MAX);

  function automatic logic [AGE_W-1:0] bump(input logic [AGE_W-1:0] a);
    return (a >= AgeSat) ? AgeSat : a + 1'b1;
  endfunction

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    logic              src_valid;
    logic              src_cmd;
    logic [DEV_W-1:0]  src_dev;
    logic [BANK_W-1:0] src_bank;
    logic [AGE_W-1:0]  src_age;

    if (i == 0) begin : g_head
      assign src_valid = 1'b1;
      assign src_cmd   = push_cmd_i;
      assign src_dev   = push_dev_i;
      assign src_bank  = push_bank_i;
      assign src_age   = '0;  // new entry reads age 1 after the edge
    end else begin : g_tail
      assign src_valid = valid_o[i-1];
      assign src_cmd   = cmd_o[i-1];
      assign src_dev   = dev_o[i-1];
      assign src_bank  = bank_o[i-1];
      assign src_age   = age_o[i-1];
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        valid_o[i] <= 1'b0;
        cmd_o[i]   <= 1'b0;
        dev_o[i]   <= '0;
        bank_o[i]  <= '0;
        age_o[i]   <= '0;
      end else if (push_i) begin
        valid_o[i] <= src_valid;
        cmd_o[i]   <= src_cmd;
        dev_o[i]   <= src_dev;
        bank_o[i]  <= src_bank;
        age_o[i]   <= bump(src_age);
      end else begin
        age_o[i]   <= bump(age_o[i]);
      end
    end
  end
endmodule

// File: rtl/rsc_pair_rule.sv
module rsc_pair_rule #(
  parameter int DEV_W    = 5,
  parameter int BANK_W   = 5,
  parameter int AGE_W    = 4,
  parameter int T_PACKET = 4,
  parameter int T_PP     = 8,
  parameter int T_BANK   = 12
) (
  input  logic              prev_valid_i,
  input  logic              prev_cmd_i,
  input  logic [DEV_W-1:0]  prev_dev_i,
  input  logic [BANK_W-1:0] prev_bank_i,
  input  logic [AGE_W-1:0]  prev_age_i,
  input  logic              new_cmd_i,
  input  logic [DEV_W-1:0]  new_dev_i,
  input  logic [BANK_W-1:0] new_bank_i,
  output logic              too_soon_o
);
  import rsc_pkg::*;

  localparam logic [AGE_W-1:0] GapBase = AGE_W'(T_PACKET);
  localparam logic [AGE_W-1:0] GapType = AGE_W'(max_int(T_PACKET, T_PP));
  localparam logic [AGE_W-1:0] GapBank = AGE_W'(max_int(T_PACKET, T_BANK));
  localparam logic [AGE_W-1:0] GapBoth = AGE_W'(max_int(max_int(T_PACKET, T_PP), T_BANK));

  logic              same_dev, same_type, same_bank, adj_bank;
  logic [BANK_W:0]   pb_ext, nb_ext;
  logic [AGE_W-1:0]  need;

  assign pb_ext    = {1'b0, prev_bank_i};
  assign nb_ext    = {1'b0, new_bank_i};
  assign same_dev  = (prev_dev_i == new_dev_i);
  assign same_type = (prev_cmd_i == new_cmd_i);
  assign same_bank = (prev_bank_i == new_bank_i);
  // neighbours share the top bank bit; no wrap, no crossing between halves
  assign adj_bank  = (prev_bank_i[BANK_W-1] == new_bank_i[BANK_W-1]) &&
                     ((pb_ext + 1'b1 == nb_ext) || (nb_ext + 1'b1 == pb_ext));

  always_comb begin
    if (!same_dev)                         need = GapBase;
    else if ((same_bank || adj_bank) && same_type) need = GapBoth;
    else if (same_bank || adj_bank)        need = GapBank;
    else if (same_type)                    need = GapType;
    else                                   need = GapBase;
  end

  assign too_soon_o = prev_valid_i && (prev_age_i < need);
endmodule

// File: rtl/rsc_spacing_eval.sv
module rsc_spacing_eval #(
  parameter int DEPTH    = 4,
  parameter int DEV_W    = 5,
  parameter int BANK_W   = 5,
  parameter int AGE_W    = 4,
  parameter int T_PACKET = 4,
  parameter int T_PP     = 8,
  parameter int T_BANK   = 12
) (
  input  logic              h_valid_i [DEPTH],
  input  logic              h_cmd_i   [DEPTH],
  input  logic [DEV_W-1:0]  h_dev_i   [DEPTH],
  input  logic [BANK_W-1:0] h_bank_i  [DEPTH],
  input  logic [AGE_W-1:0]  h_age_i   [DEPTH],
  input  logic              cmd_i,
  input  logic [DEV_W-1:0]  dev_i,
  input  logic [BANK_W-1:0] bank_i,
  output logic              conflict_o
);
  logic [DEPTH-1:0] hit;

  for (genvar i = 0; i < DEPTH; i++) begin : g_rule
    rsc_pair_rule #(
      .DEV_W(DEV_W), .BANK_W(BANK_W), .AGE_W(AGE_W),
      .T_PACKET(T_PACKET), .T_PP(T_PP), .T_BANK(T_BANK)
    ) u_rule (
      .prev_valid_i(h_valid_i[i]),
      .prev_cmd_i  (h_cmd_i[i]),
      .prev_dev_i  (h_dev_i[i]),
      .prev_bank_i (h_bank_i[i]),
      .prev_age_i  (h_age_i[i]),
      .new_cmd_i   (cmd_i),
      .new_dev_i   (dev_i),
      .new_bank_i  (bank_i),
      .too_soon_o  (hit[i])
    );
  end

  assign conflict_o = |hit;
endmodule

// File: rtl/rsc_spacing_checker.sv
module rsc_spacing_checker #(
  parameter int DEPTH    = 4,
  parameter int DEV_W    = 5,
  parameter int BANK_W   = 5,
  parameter int T_PACKET = 4,
  parameter int T_PP     = 8,
  parameter int T_BANK   = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              issue_i,
  input  logic              issue_cmd_i,
  input  logic [DEV_W-1:0]  issue_dev_i,
  input  logic [BANK_W-1:0] issue_bank_i,
  input  logic              cand_cmd_i,
  input  logic [DEV_W-1:0]  cand_dev_i,
  input  logic [BANK_W-1:0] cand_bank_i,
  output logic              ready_o,
  output logic              violation_o
);
  import rsc_pkg::*;

  localparam int MaxGap = max_int(max_int(T_PACKET, T_PP), T_BANK);
  localparam int AgeW   = $clog2(MaxGap + 1);

  logic              h_valid [DEPTH];
  logic              h_cmd   [DEPTH];
  logic [DEV_W-1:0]  h_dev   [DEPTH];
  logic [BANK_W-1:0] h_bank  [DEPTH];
  logic [AgeW-1:0]   h_age   [DEPTH];
  logic              issue_conflict, cand_conflict;

  rsc_history #(
    .DEPTH(DEPTH), .DEV_W(DEV_W), .BANK_W(BANK_W), .AGE_W(AgeW), .AGE_MAX(MaxGap)
  ) u_hist (
    .clk_i, .rst_ni,
    .push_i     (issue_i),
    .push_cmd_i (issue_cmd_i),
    .push_dev_i (issue_dev_i),
    .push_bank_i(issue_bank_i),
    .valid_o(h_valid), .cmd_o(h_cmd), .dev_o(h_dev), .bank_o(h_bank), .age_o(h_age)
  );

  rsc_spacing_eval #(
    .DEPTH(DEPTH), .DEV_W(DEV_W), .BANK_W(BANK_W), .AGE_W(AgeW),
    .T_PACKET(T_PACKET), .T_PP(T_PP), .T_BANK(T_BANK)
  ) u_eval_issue (
    .h_valid_i(h_valid), .h_cmd_i(h_cmd), .h_dev_i(h_dev), .h_bank_i(h_bank), .h_age_i(h_age),
    .cmd_i(issue_cmd_i), .dev_i(issue_dev_i), .bank_i(issue_bank_i),
    .conflict_o(issue_conflict)
  );

  rsc_spacing_eval #(
    .DEPTH(DEPTH), .DEV_W(DEV_W), .BANK_W(BANK_W), .AGE_W(AgeW),
    .T_PACKET(T_PACKET), .T_PP(T_PP), .T_BANK(T_BANK)
  ) u_eval_cand (
    .h_valid_i(h_valid), .h_cmd_i(h_cmd), .h_dev_i(h_dev), .h_bank_i(h_bank), .h_age_i(h_age),
    .cmd_i(cand_cmd_i), .dev_i(cand_dev_i), .bank_i(cand_bank_i),
    .conflict_o(cand_conflict)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) violation_o <= 1'b0;
    else         violation_o <= issue_i && issue_conflict;
  end

  assign ready_o = !cand_conflict;
endmodule

// File: rtl/rsc_spacing_checker_sva.sv
module rsc_spacing_checker_sva #(
  parameter int DEV_W  = 5,
  parameter int BANK_W = 5,
  parameter int T_BANK = 12
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              issue_i,
  input logic              issue_cmd_i,
  input logic [DEV_W-1:0]  issue_dev_i,
  input logic [BANK_W-1:0] issue_bank_i,
  input logic              cand_cmd_i,
  input logic [DEV_W-1:0]  cand_dev_i,
  input logic [BANK_W-1:0] cand_bank_i,
  input logic              ready_o,
  input logic              violation_o
);
  logic seen_q;
  logic cand_eq_issue;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      seen_q <= 1'b0;
    else if (issue_i) seen_q <= 1'b1;
  end

  assign cand_eq_issue = (cand_cmd_i == issue_cmd_i) && (cand_dev_i == issue_dev_i) &&
                         (cand_bank_i == issue_bank_i);

  // R1: first command after reset is never a violation
  assert_first_clean_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!seen_q && issue_i) |=> !violation_o);

  // R8: a violation pulse always follows an issue
  assert_pulse_source_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !issue_i |=> !violation_o);

  // R9: ready for the same command predicts the violation outcome
  assert_ready_match_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (issue_i && cand_eq_issue) |=> (violation_o == !$past(ready_o)));

  // R5: repeating the command just issued is not ready one tick later
  assert_same_bank_block_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (issue_i && (T_BANK > 1)) |=>
      (((cand_cmd_i == $past(issue_cmd_i)) && (cand_dev_i == $past(issue_dev_i)) &&
        (cand_bank_i == $past(issue_bank_i))) -> !ready_o));
endmodule

bind rsc_spacing_checker rsc_spacing_checker_sva #(
  .DEV_W(DEV_W), .BANK_W(BANK_W), .T_BANK(T_BANK)
) u_sva (
  .clk_i(clk_i), .rst_ni(rst_ni), .issue_i(issue_i), .issue_cmd_i(issue_cmd_i),
  .issue_dev_i(issue_dev_i), .issue_bank_i(issue_bank_i), .cand_cmd_i(cand_cmd_i),
  .cand_dev_i(cand_dev_i), .cand_bank_i(cand_bank_i), .ready_o(ready_o),
  .violation_o(violation_o)
);

// File: tb/rsc_spacing_checker_test.sv
module rsc_spacing_checker_test;
  localparam int TP = 4, TPP = 8, TB = 12;
  localparam logic PRE = 1'b0, ACT = 1'b1;

  logic       clk_i = 1'b0, rst_ni = 1'b0;
  logic       issue_i = 1'b0, issue_cmd_i = 1'b0, cand_cmd_i = 1'b0;
  logic [4:0] issue_dev_i = '0, issue_bank_i = '0, cand_dev_i = '0, cand_bank_i = '0;
  logic       ready_o, violation_o;
  int checks = 0, errors = 0;

  always #4 clk_i = ~clk_i;

  rsc_spacing_checker #(.T_PACKET(TP), .T_PP(TPP), .T_BANK(TB)) uut (.*);

  task automatic chk(input logic act, input logic exp, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0b expected %0b", what, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_ni = 1'b0; issue_i = 1'b0;
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
  endtask

  task automatic issue(input logic c, input logic [4:0] d, input logic [4:0] b);
    issue_i = 1'b1; issue_cmd_i = c; issue_dev_i = d; issue_bank_i = b;
    @(posedge clk_i);
    @(negedge clk_i);
    issue_i = 1'b0;
  endtask

  task automatic set_cand(input logic c, input logic [4:0] d, input logic [4:0] b);
    cand_cmd_i = c; cand_dev_i = d; cand_bank_i = b;
  endtask

  // candidate blocked at req-1 ticks, allowed at req, issue there is clean
  task automatic gap_ok(input logic ac, input logic [4:0] ad, input logic [4:0] ab,
                        input logic bc, input logic [4:0] bd, input logic [4:0] bb,
                        input int req, input string tag);
    do_reset();
    issue(ac, ad, ab);
    set_cand(bc, bd, bb);
    repeat (req - 2) @(negedge clk_i);
    #1 chk(ready_o, 1'b0, {tag, " blocked one tick early"});
    @(negedge clk_i);
    #1 chk(ready_o, 1'b1, {tag, " ready at minimum gap"});
    issue(bc, bd, bb);
    chk(violation_o, 1'b0, {tag, " no violation at minimum gap"});
  endtask

  // issue one tick early: one-cycle violation pulse
  task automatic gap_bad(input logic ac, input logic [4:0] ad, input logic [4:0] ab,
                         input logic bc, input logic [4:0] bd, input logic [4:0] bb,
                         input int req, input string tag);
    do_reset();
    issue(ac, ad, ab);
    repeat (req - 2) @(negedge clk_i);
    issue(bc, bd, bb);
    chk(violation_o, 1'b1, {tag, " violation pulse"});
    @(negedge clk_i);
    chk(violation_o, 1'b0, {tag, " pulse lasts one cycle"});
  endtask

  task automatic t_reset();
    do_reset();
    set_cand(ACT, 5'd3, 5'd7);
    #1 chk(ready_o, 1'b1, "R1 ready after reset");
    chk(violation_o, 1'b0, "R1 no violation after reset");
    issue(ACT, 5'd3, 5'd7);
    chk(violation_o, 1'b0, "R1 first command clean");
  endtask

  task automatic t_history();
    // R10: older same-bank entry still governs behind a newer entry
    do_reset();
    issue(PRE, 5'd0, 5'd3);
    repeat (TP - 1) @(negedge clk_i);
    issue(ACT, 5'd1, 5'd3);
    set_cand(PRE, 5'd0, 5'd3);
    repeat (TB - TP - 2) @(negedge clk_i);
    #1 chk(ready_o, 1'b0, "R10 older entry blocks at gap 11");
    @(negedge clk_i);
    #1 chk(ready_o, 1'b1, "R10 older entry releases at gap 12");
    // R10: violating command is recorded and restarts the window
    do_reset();
    issue(PRE, 5'd0, 5'd3);
    issue(PRE, 5'd0, 5'd3);
    chk(violation_o, 1'b1, "R10 back-to-back violation");
    set_cand(PRE, 5'd0, 5'd3);
    repeat (TB - 2) @(negedge clk_i);
    #1 chk(ready_o, 1'b0, "R10 window counts from violating command");
    @(negedge clk_i);
    #1 chk(ready_o, 1'b1, "R10 window ends from violating command");
  endtask

  initial begin
    #1_000_000;
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    gap_ok(PRE, 5'd0, 5'd5, PRE, 5'd1, 5'd5, TP, "R2 prer-prer other device");
    gap_ok(ACT, 5'd2, 5'd9, ACT, 5'd4, 5'd9, TP, "R2 act-act other device");
    gap_ok(PRE, 5'd0, 5'd5, ACT, 5'd0, 5'd9, TP, "R3 prer-act same device far bank");
    gap_ok(PRE, 5'd0, 5'd5, PRE, 5'd0, 5'd9, TPP, "R4 prer-prer same device");
    gap_ok(ACT, 5'd3, 5'd2, ACT, 5'd3, 5'd20, TPP, "R4 act-act same device");
    gap_ok(PRE, 5'd0, 5'd5, ACT, 5'd0, 5'd5, TB, "R5 same bank");
    gap_ok(PRE, 5'd0, 5'd5, ACT, 5'd0, 5'd6, TB, "R6 bank plus one");
    gap_ok(ACT, 5'd0, 5'd5, PRE, 5'd0, 5'd4, TB, "R6 bank minus one");
    gap_ok(PRE, 5'd0, 5'd15, ACT, 5'd0, 5'd16, TP, "R7 banks 15/16 split");
    gap_ok(ACT, 5'd0, 5'd0, PRE, 5'd0, 5'd31, TP, "R7 banks 0/31 no wrap");
    gap_bad(PRE, 5'd0, 5'd5, PRE, 5'd1, 5'd5, TP, "R8 other device early");
    gap_bad(PRE, 5'd0, 5'd5, PRE, 5'd0, 5'd9, TPP, "R8 same type early");
    gap_bad(PRE, 5'd0, 5'd5, ACT, 5'd0, 5'd6, TB, "R8 adjacent early");
    // R9: ready tracks the candidate within a cycle
    do_reset();
    issue(PRE, 5'd0, 5'd5);
    set_cand(ACT, 5'd0, 5'd5);
    #1 chk(ready_o, 1'b0, "R9 same-bank candidate not ready");
    set_cand(ACT, 5'd7, 5'd5);
    #1 chk(ready_o, 1'b0, "R9 other device at gap 1 not ready");
    repeat (TP - 1) @(negedge clk_i);
    #1 chk(ready_o, 1'b1, "R9 other device ready at gap 4");
    t_history();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule